// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block holds a set of hardware mutexes that several processors share through a plain 32-bit memory-mapped register interface. Each semaphore has its own word. A core claims one by writing the word with the lock flag (bit 31) set and its own identifier in bits 11:8. It then reads the word back. The claim succeeded exactly when the value read equals the value written. To release, the owner writes its identifier with the lock flag clear.

The block records the owner of each semaphore. A claim against a semaphore that is already held is dropped, as is a release from a core that does not own it. Because of this, a core that lost can keep retrying after a short back-off without disturbing the winner. Reads take one clock and return the state as it was before any write in the same cycle. Writes on the single port take effect strictly in the order they arrive, one per clock.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-low reset every semaphore is free, and a free semaphore reads as 32'h0000_0000.
- R2: A write with bit 31 set to a free semaphore makes it held by the ID in bits 11:8. A later read returns 32'h8000_0000 with that ID in bits 11:8.
- R3: A claim write to a semaphore held by a different ID is ignored. Reads keep returning the current owner with bit 31 set.
- R4: A repeated claim from the current owner leaves the semaphore held by that owner with no change.
- R5: A write with bit 31 clear whose ID matches the owner frees the semaphore, and another core can then claim it.
- R6: A release write whose ID differs from the owner's is ignored.
- R7: A release write to a free semaphore has no effect, and the semaphore stays claimable.
- R8: Only bit 31 and bits 11:8 of a write are used. All other bits of a read return zero.
- R9: Semaphore i sits at byte address 4*i, and address bits 1:0 are ignored. A write changes only the semaphore it addresses.
- R10: `rdata` updates on the clock edge that samples `rd_en` and otherwise holds its value. A read and a write to the same word in one cycle return the pre-write state.
- R11: Back-to-back writes in consecutive cycles are applied in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Byte address of the semaphore word |
| wdata | input | 32 | Write data: bit 31 lock flag, bits 11:8 core ID |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |

## Verification
The bench targets the ownership corner cases:
- A foreign claim against a held semaphore. A design that overwrote the owner here would let two cores believe they each hold the lock.
- A release carrying a mismatched ID. A design that ignored the ID would free a lock out from under its owner.
- A release of an already free word.
- Repeated claims from the owner. A design that toggled state on these would lose a held lock.
- Writes with junk in the unused bits. A design that did not mask them would fail the exact read-back compare.
- A read and a write to the same word in one cycle, and a claim, release and claim issued back to back. These expose a wrong read/write ordering or a dropped write.

// File: rtl/hsem_pkg.sv
// Package: shared constants and state encoding of the semaphore bank.
// Assumes a 32-bit data word with the lock flag in the top bit.
package hsem_pkg;
    localparam int unsigned HS_DATA_W   = 32;
    localparam int unsigned HS_LOCK_POS = 31;
    localparam int unsigned HS_ID_LSB   = 8;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_stat_e;
endpackage

// File: rtl/sem_addr_dec.sv
// Address decoder: turns a byte address into a word index and a one-hot
// write select. Assumes word-aligned access; address bits 1:0 are ignored.
module sem_addr_dec #(
    parameter int unsigned NUM_SEMS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_SEMS),
    localparam int unsigned ADDR_W  = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_SEMS-1:0] wr_sel
);
    logic unused_byte_lane;

    // Word index taken from the address above the byte lane bits.
    assign idx              = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];

    // One-hot write select: only the addressed word sees the write.
    always_comb begin
        wr_sel = '0;
        if (wr_en) wr_sel[idx] = 1'b1;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R9
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (wr_sel == '0)); // R9
endmodule

// File: rtl/sem_cell.sv
// One semaphore: holds a free/held state and the owner ID.
// A claim only takes a free cell. A release only works when the written ID
// matches the owner. All other writes leave the cell unchanged.
module sem_cell
    import hsem_pkg::*;
#(
    parameter int unsigned ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic            wr_lock,
    input  logic [ID_W-1:0] wr_id,
    output logic            held,
    output logic [ID_W-1:0] owner
);
    sem_stat_e         stat_q;
    logic [ID_W-1:0]   owner_q;

    // Ownership update: claim when free, release only by the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= SEM_FREE;
            owner_q <= '0;
        end else if (wr_hit) begin
            if (wr_lock && stat_q == SEM_FREE) begin
                stat_q  <= SEM_HELD;
                owner_q <= wr_id;
            end else if (!wr_lock && stat_q == SEM_HELD && wr_id == owner_q) begin
                stat_q  <= SEM_FREE;
                owner_q <= '0;
            end
        end
    end

    assign held  = (stat_q == SEM_HELD);
    assign owner = owner_q;

    AST_CLAIM_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && wr_lock && !held |=> held && owner == $past(wr_id)); // R2
    AST_HELD_CLAIM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && wr_lock && held |=> held && $stable(owner)); // R3
    AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && !wr_lock && held && wr_id == owner |=> !held); // R5
    AST_WRONG_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && !wr_lock && held && wr_id != owner |=> held && $stable(owner)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(held) && $stable(owner)); // R9
endmodule

// File: rtl/sem_rdmux.sv
// Read path: picks the addressed cell and registers its word image.
// A free cell reads as zero. A held cell reads as the lock flag plus the owner ID.
// rdata holds its value between reads.
module sem_rdmux
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_SEMS = 32,
    parameter int unsigned ID_W     = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_SEMS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [NUM_SEMS-1:0]            held_vec,
    input  logic [NUM_SEMS-1:0][ID_W-1:0]  owner_vec,
    output logic [HS_DATA_W-1:0]           rdata
);
    logic [HS_DATA_W-1:0] word_img;

    // Build the word image of the selected cell.
    always_comb begin
        word_img = '0;
        if (held_vec[rd_idx]) begin
            word_img[HS_LOCK_POS]            = 1'b1;
            word_img[HS_ID_LSB +: ID_W]      = owner_vec[rd_idx];
        end
    end

    // Register the read result on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= word_img;
    end

    AST_FREE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !held_vec[rd_idx] |=> rdata == '0); // R1
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10
endmodule

// File: rtl/sem_bank.sv
// Top: a bank of hardware semaphores on a plain read/write strobe port.
// One write and one read may be issued per cycle. A read returns the state
// as it was before any write in the same cycle.
module sem_bank
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_SEMS = 32,
    parameter int unsigned ID_W     = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_SEMS),
    localparam int unsigned ADDR_W  = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [HS_DATA_W-1:0] wdata,
    output logic [HS_DATA_W-1:0] rdata
);
    logic [IDX_W-1:0]               idx;
    logic [NUM_SEMS-1:0]            wr_sel;
    logic [NUM_SEMS-1:0]            held_vec;
    logic [NUM_SEMS-1:0][ID_W-1:0]  owner_vec;
    logic                           wr_lock;
    logic [ID_W-1:0]                wr_id;
    logic                           unused_wdata;

    // Split the write word into the lock flag and the ID field; the rest is dropped.
    assign wr_lock      = wdata[HS_LOCK_POS];
    assign wr_id        = wdata[HS_ID_LSB +: ID_W];
    assign unused_wdata = ^{wdata[HS_LOCK_POS-1:HS_ID_LSB+ID_W], wdata[HS_ID_LSB-1:0]};

    sem_addr_dec #(.NUM_SEMS(NUM_SEMS)) dec_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .idx    (idx),
        .wr_sel (wr_sel)
    );

    for (genvar g = 0; g < NUM_SEMS; g++) begin : g_cell
        sem_cell #(.ID_W(ID_W)) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_sel[g]),
            .wr_lock (wr_lock),
            .wr_id   (wr_id),
            .held    (held_vec[g]),
            .owner   (owner_vec[g])
        );
    end

    sem_rdmux #(.NUM_SEMS(NUM_SEMS), .ID_W(ID_W)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_idx    (idx),
        .held_vec  (held_vec),
        .owner_vec (owner_vec),
        .rdata     (rdata)
    );

    AST_FREE_ZERO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> held_vec == '0); // R1
endmodule

// File: tb/sem_bank_tb.sv
// Directed bench for sem_bank: one task per scenario, each checking itself.
module sem_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sem_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] held_word(input int id);
        return 32'h8000_0000 | (32'(id & 15) << 8);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input int sem, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 7'(sem * 4); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sem, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 7'(sem * 4);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 32; i++) begin
            rd(i, d);
            check("R1 reset free", d, 32'h0);
        end
    endtask

    task automatic t_claim_and_contend();
        logic [31:0] d;
        wr(0, 32'h8000_0100);
        rd(0, d); check("R2 claim free", d, 32'h8000_0100);
        wr(0, 32'h8000_0200);
        rd(0, d); check("R3 foreign claim", d, held_word(1));
        for (int k = 0; k < 3; k++) wr(0, 32'h8000_0100);
        rd(0, d); check("R4 repeat claim", d, held_word(1));
        wr(0, 32'h0000_0300);
        rd(0, d); check("R6 wrong release", d, held_word(1));
        wr(0, 32'h0000_0100);
        rd(0, d); check("R5 owner release", d, 32'h0);
        wr(0, 32'h8000_0200);
        rd(0, d); check("R5 reclaim after release", d, held_word(2));
        wr(0, 32'h0000_0200);
    endtask

    task automatic t_release_free();
        logic [31:0] d;
        wr(5, 32'h0000_0700);
        rd(5, d); check("R7 release of free", d, 32'h0);
        wr(5, 32'h8000_0700);
        rd(5, d); check("R7 claim after free release", d, held_word(7));
        wr(5, 32'h0000_0700);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(9, 32'hFFFF_F5FF);
        rd(9, d); check("R8 junk bits in claim", d, held_word(5));
        wr(9, 32'h7FFF_F5FF);
        rd(9, d); check("R8 junk bits in release", d, 32'h0);
    endtask

    task automatic t_indep();
        logic [31:0] d;
        for (int i = 0; i < 32; i += 2) wr(i, held_word(i));
        for (int i = 0; i < 32; i++) begin
            rd(i, d);
            check("R9 per-word select", d, (i % 2 == 0) ? held_word(i) : 32'h0);
        end
        // Byte lane bits ignored: address 4*3+2 targets semaphore 3.
        @(negedge clk); wr_en = 1'b1; addr = 7'd14; wdata = 32'h8000_0C00;
        @(negedge clk); wr_en = 1'b0;
        rd(3, d); check("R9 byte lane ignored", d, held_word(12));
        wr(3, 32'h0000_0C00);
        for (int i = 0; i < 32; i += 2) wr(i, 32'(i & 15) << 8);
        for (int i = 0; i < 32; i++) begin
            rd(i, d); check("R9 all released", d, 32'h0);
        end
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 7'd12; wdata = 32'h8000_0A00;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read sees pre-write", rdata, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 rdata holds", rdata, 32'h0);
        rd(3, d); check("R10 write landed", d, held_word(10));
        wr(3, 32'h0000_0A00);
    endtask

    task automatic t_order();
        logic [31:0] d;
        @(negedge clk); wr_en = 1'b1; addr = 7'd28; wdata = 32'h8000_0400;
        @(negedge clk); wdata = 32'h0000_0400;
        @(negedge clk); wdata = 32'h8000_0600;
        @(negedge clk); wr_en = 1'b0;
        rd(7, d); check("R11 arrival order", d, held_word(6));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_claim_and_contend();
        t_release_free();
        t_mask();
        t_indep();
        t_same_cycle();
        t_order();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule